// File: doc/BRIEF.md
# Interrupting Keyboard Input Port

This block sits between a keyboard source and a processor. The source delivers one character at a time as a single-cycle valid strobe with an 8-bit code. The block holds the latest character in a data register and marks it in a status register as ready for pickup. When the device's local interrupt-enable bit is set, the block raises a level interrupt request toward the processor.

The request is not acknowledged through any extra handshake line. It stays high, including while the service routine runs, until the processor reads the data register. That read alone clears the pending state. Software reaches the three registers over a small byte-wide register bus with a select, a write flag and a 2-bit address. Reads are combinational. Writes and the side effects of a read take hold at the next rising clock edge.

Register map: address 0 is the data register (read only), address 1 is the status register (read only), address 2 is the control register (read/write), and address 3 reads as zero.

Top module: `kbd_irq_port`

## Requirements
- R1: After reset, the data, status and control registers all read 0 and `irq` is low.
- R2: A cycle with `key_valid` high stores `key_code` into the data register and sets the ready bit (status bit 1). Both are visible from the next clock edge.
- R3: Control bit 1 is the interrupt enable and is the only writable control bit. The other control bits always read 0, so writing 0xFF reads back as 0x02.
- R4: `irq` is high exactly when the ready bit and the enable bit are both 1. Clearing the enable lowers `irq` but leaves the ready bit set.
- R5: Once raised, the request stays high across any number of idle cycles and status reads until the data register is read.
- R6: A read of the data register returns the stored code. At the next edge it clears both the ready bit and the overrun bit.
- R7: A character that arrives while the ready bit is set, with no data read in that cycle, replaces the stored code and sets the overrun bit (status bit 3).
- R8: A character that arrives in the same cycle as a data read wins. The read returns the old code, the new code is stored, the ready bit stays 1 and the overrun bit becomes 0.
- R9: Writes to the data or status address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | One-cycle strobe: a character is present |
| key_code | input | 8 | Character code that comes with the strobe |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can coincide in one cycle: a character arrival and the processor's acknowledging read of the data register. The bench raises `key_valid` in the same cycle that it presents a data-register read. It checks that the read returns the previous code. It then checks that the new code is held afterwards, that the ready bit and `irq` stay high, and that the overrun bit reads 0. A second collision, arrival against an unread character, is provoked without a read and judged by the overrun bit and the replaced code.

// File: rtl/kbd_irq_port.sv
module kbd_irq_port #(
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int RDY_BIT = 1,
  parameter int OVR_BIT = 3,
  parameter int IE_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CODE_W-1:0] key_code,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CODE_W-1:0] bus_wdata,
  output logic [CODE_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);

  logic [CODE_W-1:0] code_q;
  logic              rdy_q, ovr_q, ie_q;
  logic [CODE_W-1:0] stat_w, ctrl_w;

  wire rd_any  = bus_sel && !bus_we;
  wire rd_data = rd_any && bus_addr == A_DATA;
  wire wr_ctrl = bus_sel && bus_we && bus_addr == A_CTRL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (key_valid) begin
        code_q <= key_code;
        rdy_q  <= 1'b1;
        ovr_q  <= rd_data ? 1'b0 : (ovr_q | rdy_q);
      end else if (rd_data) begin
        rdy_q <= 1'b0;
        ovr_q <= 1'b0;
      end
      if (wr_ctrl) ie_q <= bus_wdata[IE_BIT];
    end
  end

  always_comb begin
    stat_w          = '0;
    stat_w[RDY_BIT] = rdy_q;
    stat_w[OVR_BIT] = ovr_q;
    ctrl_w          = '0;
    ctrl_w[IE_BIT]  = ie_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      case (bus_addr)
        A_DATA:  bus_rdata = code_q;
        A_STAT:  bus_rdata = stat_w;
        A_CTRL:  bus_rdata = ctrl_w;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = rdy_q & ie_q;
endmodule

// File: rtl/kbd_irq_port_chk.sv
module kbd_irq_port_chk #(
  parameter int ADDR_W = 2,
  parameter int CODE_W = 8,
  parameter int IE_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CODE_W-1:0] bus_wdata,
  input logic              irq,
  input logic              rdy_q,
  input logic              ovr_q,
  input logic              ie_q
);
  wire rd0 = bus_sel && !bus_we && bus_addr == '0;
  wire wc  = bus_sel && bus_we && bus_addr == ADDR_W'(2);

  p_arrival_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> rdy_q);
  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q && rdy_q);
  p_disable_drops_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wc && !bus_wdata[IE_BIT] |=> !irq);
  p_request_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q && !rd0 |=> rdy_q);
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && !key_valid |=> !rdy_q && !ovr_q);
  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && rdy_q && !rd0 |=> ovr_q);
  p_collision_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && rd0 |=> rdy_q && !ovr_q);
endmodule

bind kbd_irq_port kbd_irq_port_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .IE_BIT(IE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .bus_sel(bus_sel),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
  .rdy_q(rdy_q), .ovr_q(ovr_q), .ie_q(ie_q)
);

// File: tb/kbd_irq_port_bench.sv
module kbd_irq_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_valid = 1'b0;
  logic [7:0] key_code = '0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  kbd_irq_port u_kbd_irq_port (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk); key_valid = 1; key_code = c;
    @(negedge clk); key_valid = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R1 data", d, 8'h00);
    rd(2'd1, d); check("R1 status", d, 8'h00);
    rd(2'd2, d); check("R1 ctrl", d, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(2'd2, 8'hFF); rd(2'd2, d); check("R3 ctrl mask", d, 8'h02);
    wr(2'd2, 8'h00); rd(2'd2, d); check("R3 ctrl clear", d, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    wr(2'd2, 8'h02);
    key(8'h41);
    check("R2 irq after key", {7'b0, irq}, 8'h01);
    rd(2'd1, d); check("R2 status ready", d, 8'h02);
    repeat (5) @(negedge clk);
    rd(2'd1, d);
    check("R5 irq held", {7'b0, irq}, 8'h01);
    rd(2'd0, d); check("R6 data", d, 8'h41);
    check("R6 irq cleared", {7'b0, irq}, 8'h00);
    rd(2'd1, d); check("R6 status clear", d, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    key(8'h5A);
    wr(2'd2, 8'h00);
    check("R4 irq off", {7'b0, irq}, 8'h00);
    rd(2'd1, d); check("R4 ready kept", d, 8'h02);
    wr(2'd2, 8'h02);
    check("R4 irq back", {7'b0, irq}, 8'h01);
    rd(2'd0, d); check("R4 data", d, 8'h5A);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    key(8'h31); key(8'h32);
    rd(2'd1, d); check("R7 overrun", d, 8'h0A);
    rd(2'd0, d); check("R7 newest", d, 8'h32);
    rd(2'd1, d); check("R6 overrun clear", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    key(8'h61);
    @(negedge clk); key_valid = 1; key_code = 8'h62;
    bus_sel = 1; bus_we = 0; bus_addr = 2'd0;
    #1 d = bus_rdata;
    @(negedge clk); key_valid = 0; bus_sel = 0;
    check("R8 old code read", d, 8'h61);
    check("R8 irq stays", {7'b0, irq}, 8'h01);
    rd(2'd1, d); check("R8 status", d, 8'h02);
    rd(2'd0, d); check("R8 new code", d, 8'h62);
  endtask

  task automatic t_ro();
    logic [7:0] d;
    key(8'h77);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    rd(2'd1, d); check("R9 status kept", d, 8'h02);
    check("R9 irq kept", {7'b0, irq}, 8'h01);
    rd(2'd0, d); check("R9 data kept", d, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_ctrl(); t_basic(); t_gate(); t_overrun(); t_collide(); t_ro();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule